// File: doc/BRIEF.md
# Operand register file with registered reads and write forwarding

This block is the operand store of an execution pipeline. It keeps 64 entries of 64 bits: the lower half (indices 0 to 31) holds the integer registers and the upper half (32 to 63) holds the floating-point registers. Reads are synchronous, so the array can map onto block RAM. The decode stage presents three source indices every cycle, one clock before the operands are needed. It does so whether or not the instruction uses all three.

A stall input freezes the three captured indices. While the pipeline waits, the same entries are read again each cycle, so a write that lands during the stall still shows up. The last write is kept in a small register. Any read port whose captured index equals that write index returns the kept data instead of the RAM word. This covers the cycle in which the RAM has not yet absorbed the write.

A debug reader shares the second read port. Its request waits until a cycle that is free for it: no stall, and either no valid instruction or an instruction that leaves its second operand unused. The entry then comes back on the debug data output together with a one-cycle valid pulse.

Top module: `opnd_regfile`

## Requirements
- R1: The file holds 64 independent 64-bit entries. Index bit 5 selects the half: 0 to 31 are integer registers and 32 to 63 are floating-point registers, and a write to one index never changes another.
- R2: A read index sampled at a clock edge produces its entry on the matching output right after that edge, and the output holds until the next edge.
- R3: The three read ports (`src_a`, `src_b`, `src_c`) work independently and at the same time, whatever their indices.
- R4: While `stall` is 1 at an edge, the new read indices are ignored. The indices captured earlier are read again, and the outputs show their current contents.
- R5: If `wr_en` is 1 at an edge and a read port's index for that edge equals `wr_idx`, that port returns `wr_data` right after the edge.
- R6: Forwarding needs `wr_en`. With `wr_en` at 0, a matching `wr_idx` never puts `wr_data` on a read port.
- R7: A held `dbg_req` is granted at an edge only when `stall` is 0 and `inst_valid && uses_b` is 0. Otherwise it stays pending and `dbg_valid` stays 0.
- R8: Right after the granting edge, `dbg_valid` is 1 for exactly one cycle, and `dbg_data` carries the entry at `dbg_idx`. The requester holds `dbg_req` and `dbg_idx` until it sees `dbg_valid`.
- R9: While `rst_n` is 0, all read outputs, `dbg_data` and `dbg_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Holds the captured read indices |
| inst_valid | input | 1 | A valid instruction is in decode |
| uses_b | input | 1 | The instruction reads its second operand |
| idx_a | input | 6 | Read index, port A |
| idx_b | input | 6 | Read index, port B |
| idx_c | input | 6 | Read index, port C |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data |
| dbg_req | input | 1 | Debug read request, held until granted |
| dbg_idx | input | 6 | Debug read index |
| src_a | output | 64 | Operand, port A |
| src_b | output | 64 | Operand, port B |
| src_c | output | 64 | Operand, port C |
| dbg_valid | output | 1 | Debug data valid pulse |
| dbg_data | output | 64 | Debug read data |

## Verification
Every result of this block is due exactly one edge after its inputs are sampled. This holds for the operands, for forwarded write data and for the debug pulse. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge; the model is written from the requirements. It then compares all outputs on the next falling edge, so each check sees the values produced by that single edge. The stall sequences follow the same rule: every held cycle is compared against the entry read again at the captured index, not against the new index.

// File: rtl/opnd_regfile.sv
module opnd_regfile #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          inst_valid,
  input  logic          uses_b,
  input  logic [AW-1:0] idx_a,
  input  logic [AW-1:0] idx_b,
  input  logic [AW-1:0] idx_c,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          dbg_req,
  input  logic [AW-1:0] dbg_idx,
  output logic [DW-1:0] src_a,
  output logic [DW-1:0] src_b,
  output logic [DW-1:0] src_c,
  output logic          dbg_valid,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;
  localparam int NPORT = 3;

  logic [DW-1:0] mem [DEPTH];

  logic          wq_en;
  logic [AW-1:0] wq_idx;
  logic [DW-1:0] wq_data;
  logic          dbg_busy;
  logic          dbg_go;

  logic [AW-1:0] ain  [NPORT];
  logic [AW-1:0] asel [NPORT];
  logic [AW-1:0] aq   [NPORT];
  logic [DW-1:0] dq   [NPORT];
  logic [DW-1:0] dout [NPORT];

  assign dbg_go = dbg_req & ~dbg_busy & ~stall & ~(inst_valid & uses_b);

  assign ain[0] = idx_a;
  assign ain[1] = dbg_go ? dbg_idx : idx_b;
  assign ain[2] = idx_c;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq_en    <= 1'b0;
      wq_idx   <= '0;
      wq_data  <= '0;
      dbg_busy <= 1'b0;
    end else begin
      wq_en    <= wr_en;
      wq_idx   <= wr_idx;
      wq_data  <= wr_data;
      dbg_busy <= dbg_go;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign asel[p] = stall ? aq[p] : ain[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        aq[p] <= '0;
        dq[p] <= '0;
      end else begin
        aq[p] <= asel[p];
        dq[p] <= mem[asel[p]];
      end
    end

    assign dout[p] = (wq_en && wq_idx == aq[p]) ? wq_data : dq[p];
  end

  assign src_a     = dout[0];
  assign src_b     = dout[1];
  assign src_c     = dout[2];
  assign dbg_valid = dbg_busy;
  assign dbg_data  = dbg_busy ? dout[1] : '0;
endmodule

// File: rtl/opnd_regfile_chk.sv
module opnd_regfile_chk #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          inst_valid,
  input logic          uses_b,
  input logic [AW-1:0] idx_a,
  input logic [AW-1:0] idx_c,
  input logic          wr_en,
  input logic [AW-1:0] wr_idx,
  input logic [DW-1:0] wr_data,
  input logic          dbg_req,
  input logic [DW-1:0] src_a,
  input logic [DW-1:0] src_b,
  input logic [DW-1:0] src_c,
  input logic          dbg_valid
);
  logic up;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_valid |=> !dbg_valid);

  a_r7_free_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_valid |-> $past(dbg_req && !stall && !(inst_valid && uses_b)));

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up && stall && !wr_en) |=> ($stable(src_a) && $stable(src_b) && $stable(src_c)));

  a_r5_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stall && wr_idx == idx_a) |=> (src_a == $past(wr_data)));

  a_r5_fwd_c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stall && wr_idx == idx_c) |=> (src_c == $past(wr_data)));
endmodule

bind opnd_regfile opnd_regfile_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .inst_valid(inst_valid),
  .uses_b(uses_b), .idx_a(idx_a), .idx_c(idx_c), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data), .dbg_req(dbg_req),
  .src_a(src_a), .src_b(src_b), .src_c(src_c), .dbg_valid(dbg_valid)
);

// File: tb/opnd_regfile_bench.sv
module opnd_regfile_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0, inst_valid = 1'b0, uses_b = 1'b0;
  logic [5:0]  idx_a = '0, idx_b = '0, idx_c = '0, wr_idx = '0, dbg_idx = '0;
  logic        wr_en = 1'b0, dbg_req = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] src_a, src_b, src_c, dbg_data;
  logic        dbg_valid;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b1;
  string tag = "R9";

  logic [63:0] ref_mem [64];
  logic [5:0]  h_a = '0, h_b = '0, h_c = '0;
  logic [63:0] e_a = '0, e_b = '0, e_c = '0;
  logic        e_dv = 1'b0, m_infl = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  opnd_regfile u_opnd_regfile (
    .clk(clk), .rst_n(rst_n), .stall(stall), .inst_valid(inst_valid),
    .uses_b(uses_b), .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .dbg_req(dbg_req), .dbg_idx(dbg_idx),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .dbg_valid(dbg_valid), .dbg_data(dbg_data)
  );

  function automatic logic [63:0] rd_model(input logic [5:0] s);
    return (wr_en && wr_idx == s) ? wr_data : ref_mem[s];
  endfunction

  task automatic model_edge();
    logic [5:0] sa, sb, sc;
    logic iss;
    if (!rst_n) begin
      h_a = '0; h_b = '0; h_c = '0;
      e_a = '0; e_b = '0; e_c = '0;
      e_dv = 1'b0; m_infl = 1'b0;
    end else begin
      iss = dbg_req && !m_infl && !stall && !(inst_valid && uses_b);
      sa = stall ? h_a : idx_a;
      sb = stall ? h_b : (iss ? dbg_idx : idx_b);
      sc = stall ? h_c : idx_c;
      e_a = rd_model(sa);
      e_b = rd_model(sb);
      e_c = rd_model(sc);
      if (wr_en) ref_mem[wr_idx] = wr_data;
      h_a = sa; h_b = sb; h_c = sc;
      m_infl = iss;
      e_dv = iss;
    end
  endtask

  task automatic check_eq(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare();
    if (!chk_en) return;
    check_eq({tag, " src_a"}, src_a, e_a);
    check_eq({tag, " src_b"}, src_b, e_b);
    check_eq({tag, " src_c"}, src_c, e_c);
    check_eq({tag, " R8 dbg_valid"}, {63'd0, dbg_valid}, {63'd0, e_dv});
    if (e_dv) check_eq({tag, " R8 dbg_data"}, dbg_data, e_b);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    stall = 0; inst_valid = 0; uses_b = 0; wr_en = 0; dbg_req = 0;
    idx_a = 0; idx_b = 0; idx_c = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] x, y, z;
    void'($urandom(32'd2024));
    @(negedge clk);
    tag = "R9";
    compare();
    tick();
    rst_n = 1'b1;

    chk_en = 1'b0;
    for (int i = 0; i < 64; i++) begin
      wr_en = 1; wr_idx = 6'(i); wr_data = {$urandom, $urandom};
      tick();
    end
    idle();
    tick(); tick();
    chk_en = 1'b1;

    tag = "R1";
    x = 64'h1111_2222_3333_0005; y = 64'h9999_AAAA_BBBB_0025;
    wr_en = 1; wr_idx = 6'd5; wr_data = x; tick();
    wr_idx = 6'd37; wr_data = y; tick();
    wr_en = 0; idx_a = 6'd5; idx_b = 6'd37; inst_valid = 1; uses_b = 1; tick();
    check_eq("R1 integer half", src_a, x);
    check_eq("R1 float half", src_b, y);

    tag = "R2";
    idle(); idx_a = 6'd12; tick();
    check_eq("R2 latency", src_a, ref_mem[12]);
    idx_a = 6'd13; tick();
    check_eq("R2 next index", src_a, ref_mem[13]);

    tag = "R4";
    idx_a = 6'd20; idx_c = 6'd50; tick();
    stall = 1; idx_a = 6'd21; idx_c = 6'd51;
    tick(); tick();
    check_eq("R4 held index", src_a, ref_mem[20]);
    wr_en = 1; wr_idx = 6'd50; wr_data = 64'hDEAD_BEEF_0000_0050; tick();
    wr_en = 0; tick();
    check_eq("R4 refresh during stall", src_c, 64'hDEAD_BEEF_0000_0050);
    stall = 0; tick();
    check_eq("R4 release", src_a, ref_mem[21]);

    tag = "R5";
    z = 64'h5A5A_0000_0000_001E;
    idle(); wr_en = 1; wr_idx = 6'd30; wr_data = z; idx_a = 6'd30; idx_c = 6'd30; tick();
    check_eq("R5 same cycle a", src_a, z);
    check_eq("R5 same cycle c", src_c, z);

    tag = "R6";
    wr_en = 0; wr_idx = 6'd30; wr_data = 64'hFFFF_0000_FFFF_0000; tick();
    check_eq("R6 no enable no forward", src_a, z);

    tag = "R7";
    idle(); inst_valid = 1; uses_b = 1; dbg_req = 1; dbg_idx = 6'd37;
    tick(); tick();
    check_eq("R7 blocked", {63'd0, dbg_valid}, 64'd0);
    inst_valid = 0; stall = 1; tick();
    check_eq("R7 blocked by stall", {63'd0, dbg_valid}, 64'd0);
    stall = 0; inst_valid = 1; uses_b = 0; tick();
    tag = "R8";
    check_eq("R8 valid pulse", {63'd0, dbg_valid}, 64'd1);
    check_eq("R8 debug data", dbg_data, y);
    dbg_req = 0; tick();
    check_eq("R8 pulse ends", {63'd0, dbg_valid}, 64'd0);

    tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      stall      = ($urandom % 4) == 0;
      inst_valid = $urandom % 2;
      uses_b     = $urandom % 2;
      idx_a      = 6'($urandom); idx_b = 6'($urandom); idx_c = 6'($urandom);
      wr_en      = $urandom % 2;
      wr_idx     = ($urandom % 3 == 0) ? idx_a : 6'($urandom);
      wr_data    = {$urandom, $urandom};
      if (dbg_valid) dbg_req = 0;
      else if (!dbg_req) begin
        dbg_req = ($urandom % 3) == 0;
        dbg_idx = 6'($urandom);
      end
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule